// File: doc/BRIEF.md
# Accumulator CPU Sequencer with Bus-Grant Hold

This block is the sequencing half of a small accumulator CPU, together with the register datapath it steers. It steps each instruction through a three-state fetch followed by one or more execute states. A direct memory access engine can take over the system bus by raising a request input. The CPU answers only when it is back at the first fetch state, after the previous instruction has fully completed. There it loads a registered grant from the request on every clock and waits in that state until the request is withdrawn.

The address and control output enables are the inverse of the grant. Board-level buffers therefore release the bus exactly while the grant is high. A separate flag marks the execute states that never touch the bus, so a controller that moves data only in idle bus cycles can use them. Four instructions exercise the state flow:

- a no-operation
- a load of the accumulator from a 16-bit address
- a jump to a 16-bit address
- a clear of the accumulator

Top module: `dmacpu_top`

## Requirements
- R1: While reset is low and in the first cycle after it, busGrant is 0, addrOe and ctrlOe are 1, memRead is 0, and the sequencer is in the first fetch state.
- R2: In the first fetch state with busReq high, busGrant is 1 from the next cycle on. The sequencer stays in that state, addrOut does not change and memRead is 0, for as long as busReq stays high.
- R3: busGrant is a register output: a change on busReq never alters busGrant before the next rising clock edge.
- R4: When busReq is low at a clock edge in the first fetch state, busGrant becomes 0 and addrOut takes the program counter at that edge. The next cycle is a memory read.
- R5: addrOe and ctrlOe always equal the inverse of busGrant.
- R6: busReq sampled in any state other than the first fetch state changes neither busGrant nor the instruction timing.
- R7: A request raised in the middle of an instruction is granted only after that instruction's last execute state has completed.
- R8: busFree is 1 only in the execute states that leave the bus idle: no-operation, the final state of the load (accumulator from data register), the final state of the jump (program counter from the fetched address), and the clear.
- R9: Opcodes are 0x00 no-operation (4 cycles) and 0x08 clear (4 cycles, accumulator 0, zero flag 1). 0x01 is the load (8 cycles, address low byte then high byte, zero flag set when the loaded value is 0). 0x05 is the jump (6 cycles, low byte then high byte). Any other opcode acts as a no-operation.
- R10: Memory reads happen, in order, at the opcode address, then at each operand byte address, then (for a load) at the target address. memRead is never 1 while busGrant is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| busReq | input | 1 | Bus request from the DMA engine |
| dataIn | input | 8 | Read data from memory |
| busGrant | output | 1 | Registered bus grant |
| addrOut | output | 16 | Address register contents |
| addrOe | output | 1 | Enable for the address bus buffers |
| ctrlOe | output | 1 | Enable for the control bus buffers |
| memRead | output | 1 | Memory read strobe |
| busFree | output | 1 | Current state leaves the bus unused |
| accOut | output | 8 | Accumulator |
| zeroOut | output | 1 | Zero flag |

## Verification
Two things can meet at the same clock edge in the first fetch state. One is the grant update. The other is the address load for the fetch, which starts the next instruction. The bench withdraws the request in a stalled fetch state and expects, in the following cycle, the grant low, the enables high and the program counter on addrOut as the next read. It also raises the request during the idle final state of a jump, so that the ignored sample and the honoured one fall on consecutive edges. It judges that the grant then lasts exactly one cycle and that the ordered read stream is unchanged.

// File: rtl/dmacpu_pkg.sv
package dmacpu_pkg;

  typedef enum logic [3:0] {
    ST_FETCH1, ST_FETCH2, ST_FETCH3,
    ST_NOP1,
    ST_LDAC1, ST_LDAC2, ST_LDAC3, ST_LDAC4, ST_LDAC5,
    ST_JUMP1, ST_JUMP2, ST_JUMP3,
    ST_CLAC1
  } cuState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic arFromPc;   // address register <- program counter
    logic arFromDt;   // address register <- {data reg, temp reg}
    logic arInc;      // address register + 1
    logic pcInc;      // program counter + 1
    logic pcFromDt;   // program counter <- {data reg, temp reg}
    logic drFromMem;  // data register <- memory
    logic trFromDr;   // temp register <- data register
    logic acFromDr;   // accumulator <- data register, zero flag updated
    logic acClear;    // accumulator <- 0, zero flag <- 1
  } strobe_t;

  localparam logic [7:0] OP_NOP  = 8'h00;
  localparam logic [7:0] OP_LDAC = 8'h01;
  localparam logic [7:0] OP_JUMP = 8'h05;
  localparam logic [7:0] OP_CLAC = 8'h08;

endpackage

// File: rtl/dmacpu_control.sv
module dmacpu_control
  import dmacpu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReq,
  input  logic [DATA_W-1:0] drByte,
  output strobe_t           strobe,
  output logic              grant,
  output logic              readStrobe,
  output logic              idleBus
);

  cuState_t state, nextState;
  logic     grantQ;

  always_comb begin
    nextState  = state;
    strobe     = '0;
    readStrobe = 1'b0;
    idleBus    = 1'b0;
    unique case (state)
      ST_FETCH1: begin
        if (!busReq) begin
          strobe.arFromPc = 1'b1;
          nextState       = ST_FETCH2;
        end
      end
      ST_FETCH2: begin
        strobe.drFromMem = 1'b1;
        strobe.pcInc     = 1'b1;
        readStrobe       = 1'b1;
        nextState        = ST_FETCH3;
      end
      ST_FETCH3: begin
        strobe.arFromPc = 1'b1;
        case (drByte[7:0])
          OP_LDAC: nextState = ST_LDAC1;
          OP_JUMP: nextState = ST_JUMP1;
          OP_CLAC: nextState = ST_CLAC1;
          default: nextState = ST_NOP1;
        endcase
      end
      ST_NOP1: begin
        idleBus   = 1'b1;
        nextState = ST_FETCH1;
      end
      ST_LDAC1: begin
        strobe.drFromMem = 1'b1;
        strobe.pcInc     = 1'b1;
        strobe.arInc     = 1'b1;
        readStrobe       = 1'b1;
        nextState        = ST_LDAC2;
      end
      ST_LDAC2: begin
        strobe.trFromDr  = 1'b1;
        strobe.drFromMem = 1'b1;
        strobe.pcInc     = 1'b1;
        readStrobe       = 1'b1;
        nextState        = ST_LDAC3;
      end
      ST_LDAC3: begin
        strobe.arFromDt = 1'b1;
        nextState       = ST_LDAC4;
      end
      ST_LDAC4: begin
        strobe.drFromMem = 1'b1;
        readStrobe       = 1'b1;
        nextState        = ST_LDAC5;
      end
      ST_LDAC5: begin
        strobe.acFromDr = 1'b1;
        idleBus         = 1'b1;
        nextState       = ST_FETCH1;
      end
      ST_JUMP1: begin
        strobe.drFromMem = 1'b1;
        strobe.arInc     = 1'b1;
        readStrobe       = 1'b1;
        nextState        = ST_JUMP2;
      end
      ST_JUMP2: begin
        strobe.trFromDr  = 1'b1;
        strobe.drFromMem = 1'b1;
        readStrobe       = 1'b1;
        nextState        = ST_JUMP3;
      end
      ST_JUMP3: begin
        strobe.pcFromDt = 1'b1;
        idleBus         = 1'b1;
        nextState       = ST_FETCH1;
      end
      ST_CLAC1: begin
        strobe.acClear = 1'b1;
        idleBus        = 1'b1;
        nextState      = ST_FETCH1;
      end
      default: nextState = ST_FETCH1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_FETCH1;
      grantQ <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_FETCH1) grantQ <= busReq;
    end
  end

  assign grant = grantQ;

endmodule

// File: rtl/dmacpu_datapath.sv
module dmacpu_datapath
  import dmacpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [DATA_W-1:0] memData,
  output logic [ADDR_W-1:0] arOut,
  output logic [DATA_W-1:0] drOut,
  output logic [DATA_W-1:0] acOut,
  output logic              zOut
);

  localparam int DT_W = 2 * DATA_W;

  logic [ADDR_W-1:0] pcReg, arReg;
  logic [DATA_W-1:0] drReg, trReg, acReg;
  logic              zReg;
  logic [DT_W-1:0]   dtWord;

  assign dtWord = {drReg, trReg};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcReg <= '0;
      arReg <= '0;
      drReg <= '0;
      trReg <= '0;
      acReg <= '0;
      zReg  <= 1'b0;
    end else begin
      if (strobe.pcInc)         pcReg <= pcReg + 1'b1;
      else if (strobe.pcFromDt) pcReg <= dtWord[ADDR_W-1:0];

      if (strobe.arFromPc)      arReg <= pcReg;
      else if (strobe.arFromDt) arReg <= dtWord[ADDR_W-1:0];
      else if (strobe.arInc)    arReg <= arReg + 1'b1;

      if (strobe.drFromMem)     drReg <= memData;
      if (strobe.trFromDr)      trReg <= drReg;

      if (strobe.acClear) begin
        acReg <= '0;
        zReg  <= 1'b1;
      end else if (strobe.acFromDr) begin
        acReg <= drReg;
        zReg  <= (drReg == '0);
      end
    end
  end

  assign arOut = arReg;
  assign drOut = drReg;
  assign acOut = acReg;
  assign zOut  = zReg;

endmodule

// File: rtl/dmacpu_top.sv
module dmacpu_top
  import dmacpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReq,
  input  logic [DATA_W-1:0] dataIn,
  output logic              busGrant,
  output logic [ADDR_W-1:0] addrOut,
  output logic              addrOe,
  output logic              ctrlOe,
  output logic              memRead,
  output logic              busFree,
  output logic [DATA_W-1:0] accOut,
  output logic              zeroOut
);

  strobe_t           strobe;
  logic [DATA_W-1:0] drByte;
  logic              grant;

  dmacpu_control #(.DATA_W(DATA_W)) i_control (
    .clk        (clk),
    .rstN       (rstN),
    .busReq     (busReq),
    .drByte     (drByte),
    .strobe     (strobe),
    .grant      (grant),
    .readStrobe (memRead),
    .idleBus    (busFree)
  );

  dmacpu_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .memData (dataIn),
    .arOut   (addrOut),
    .drOut   (drByte),
    .acOut   (accOut),
    .zOut    (zeroOut)
  );

  assign busGrant = grant;
  assign addrOe   = ~grant;
  assign ctrlOe   = ~grant;

endmodule

// File: rtl/dmacpu_checker.sv
module dmacpu_checker #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              busReq,
  input logic              busGrant,
  input logic [ADDR_W-1:0] addrOut,
  input logic              addrOe,
  input logic              ctrlOe,
  input logic              memRead,
  input logic              busFree
);

  // R5
  enables_follow_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addrOe == !busGrant) && (ctrlOe == !busGrant));

  // R2
  hold_while_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busGrant && busReq) |=> (busGrant && $stable(addrOut)));

  // R4
  release_then_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busGrant && !busReq) |=> (!busGrant && memRead));

  // R10
  no_read_when_granted_chk: assert property (@(posedge clk) disable iff (!rstN)
    busGrant |-> (!memRead && !busFree));

  // R6
  no_grant_from_exec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busGrant && busFree) |=> !busGrant);

  // R7
  grant_needs_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busGrant) |-> $past(busReq));

endmodule

bind dmacpu_top dmacpu_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_checker (
  .clk      (clk),
  .rstN     (rstN),
  .busReq   (busReq),
  .busGrant (busGrant),
  .addrOut  (addrOut),
  .addrOe   (addrOe),
  .ctrlOe   (ctrlOe),
  .memRead  (memRead),
  .busFree  (busFree)
);

// File: tb/test_dmacpu_top.sv
module test_dmacpu_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busReq = 1'b0;
  logic [7:0]  dataIn;
  logic        busGrant;
  logic [15:0] addrOut;
  logic        addrOe, ctrlOe, memRead, busFree;
  logic [7:0]  accOut;
  logic        zeroOut;

  logic [7:0]  mem [256];
  logic [15:0] expReads[$];
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  always #2 clk = ~clk;  // 250 MHz

  assign dataIn = mem[addrOut[7:0]];

  dmacpu_top i_dmacpu_top (
    .clk(clk), .rstN(rstN), .busReq(busReq), .dataIn(dataIn),
    .busGrant(busGrant), .addrOut(addrOut), .addrOe(addrOe), .ctrlOe(ctrlOe),
    .memRead(memRead), .busFree(busFree), .accOut(accOut), .zeroOut(zeroOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pushRead(input logic [15:0] a);
    expReads.push_back(a);
  endtask

  // scoreboard monitor: each read compared against the expected order (R10)
  always @(negedge clk) begin
    if (rstN && memRead && !done) begin
      if (expReads.size() == 0) check("R10 unexpected read", {16'h0, addrOut}, 32'hFFFF_FFFF);
      else check("R10 read address", {16'h0, addrOut}, {16'h0, expReads.pop_front()});
      check("R10 no read while granted", busGrant, 1'b0);
    end
  end

  initial begin
    #40000;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    mem[8'h00] = 8'h00;                                   // NOP
    mem[8'h01] = 8'h08;                                   // CLAC
    mem[8'h02] = 8'h01; mem[8'h03] = 8'h40; mem[8'h04] = 8'h00; // LDAC 0x0040
    mem[8'h05] = 8'h05; mem[8'h06] = 8'h10; mem[8'h07] = 8'h00; // JUMP 0x0010
    mem[8'h10] = 8'h01; mem[8'h11] = 8'h41; mem[8'h12] = 8'h00; // LDAC 0x0041
    mem[8'h13] = 8'h05; mem[8'h14] = 8'h00; mem[8'h15] = 8'h00; // JUMP 0x0000
    mem[8'h40] = 8'h5A;
    mem[8'h41] = 8'h00;

    // driver: expected read stream for the whole run
    pushRead(16'h0000); pushRead(16'h0001);
    pushRead(16'h0002); pushRead(16'h0003); pushRead(16'h0004); pushRead(16'h0040);
    pushRead(16'h0005); pushRead(16'h0006); pushRead(16'h0007);
    pushRead(16'h0010); pushRead(16'h0011); pushRead(16'h0012); pushRead(16'h0041);
    pushRead(16'h0013); pushRead(16'h0014); pushRead(16'h0015);
    pushRead(16'h0000);

    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 grant in reset", busGrant, 1'b0);
    check("R1 addrOe in reset", addrOe, 1'b1);
    check("R1 ctrlOe in reset", ctrlOe, 1'b1);
    check("R1 memRead in reset", memRead, 1'b0);
    rstN = 1'b1;

    for (int c = 0; c <= 45; c++) begin
      bit expBg, expFree;
      if (c != 0) @(negedge clk);
      expBg   = ((c >= 31 && c <= 35) || c == 42);
      expFree = (c == 3 || c == 7 || c == 15 || c == 21 || c == 29 || c == 40 || c == 45);
      check("R2/R6/R7 busGrant", busGrant, expBg);
      check("R5 addrOe", addrOe, !expBg);
      check("R5 ctrlOe", ctrlOe, !expBg);
      check("R8 busFree", busFree, expFree);
      if (c == 0) begin
        check("R1 first cycle grant", busGrant, 1'b0);
        check("R1 first cycle no read", memRead, 1'b0);
      end
      if (c == 1)  check("R1 fetch starts at address 0", addrOut, 16'h0000);
      if (c == 8)  begin check("R9 clear acc", accOut, 8'h00); check("R9 clear zero", zeroOut, 1'b1); end
      if (c == 16) begin check("R9 load acc", accOut, 8'h5A); check("R9 load zero", zeroOut, 1'b0); end
      if (c == 17) check("R9 next fetch address", addrOut, 16'h0005);
      if (c == 23) check("R9 jump target", addrOut, 16'h0010);
      if (c == 30) begin check("R9 load zero value", accOut, 8'h00); check("R9 load zero flag", zeroOut, 1'b1); end
      if (c >= 31 && c <= 35) begin
        check("R2 address held", addrOut, 16'h0041);
        check("R2 no read in hold", memRead, 1'b0);
      end
      if (c == 36) begin
        check("R4 address from PC", addrOut, 16'h0013);
        check("R4 read after release", memRead, 1'b1);
      end
      if (c == 43) begin
        check("R4 one-cycle grant then fetch", addrOut, 16'h0000);
        check("R4 read after short grant", memRead, 1'b1);
      end
      // request stimulus
      busReq = ((c >= 23 && c <= 34) || (c >= 40 && c <= 41));
      if (c == 30) begin
        #1 check("R3 grant not combinational on rise", busGrant, 1'b0);
      end
      if (c == 42) begin
        #1 check("R3 grant not combinational on fall", busGrant, 1'b1);
      end
    end
    @(negedge clk);
    done = 1;
    check("R10 all reads seen", expReads.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule